// File: doc/BRIEF.md
# Per-Thread Squash Request Controller

This block sits beside the commit logic of one hardware thread and decides, each cycle, whether that thread must be squashed and where the squash boundary lies. It takes three squash sources. The first is a trap squash that fires a fixed number of cycles after a trap is taken. The second is an external thread-context squash request. The third is an execute-stage squash that carries a sequence number and branch-mispredict details. It issues at most one registered squash command toward the reorder buffer and the front-end stages.

The block tracks the youngest sequence number allocated to the thread. It uses that value to reject execute squashes that are younger than the current squash point. It derives two boundaries: the sequence number reported as done, and the one handed to the reorder buffer, which differs when a branch delay slot survives. It also drives the restart PC and the mispredict details.

The thread state machine has three states. RUNNING (code 0) is the normal state. TRAP_PENDING (code 1) holds while the trap latency counts down. ROB_SQUASHING (code 2) holds from an accepted squash until the reorder buffer reports that its walk is complete. The transitions are:

- RUNNING to TRAP_PENDING on trap-take.
- RUNNING to ROB_SQUASHING on any accepted squash.
- ROB_SQUASHING to RUNNING on walk-done.
- ROB_SQUASHING to ROB_SQUASHING on a new accepted squash.
- ROB_SQUASHING to TRAP_PENDING on trap-take.
- TRAP_PENDING to ROB_SQUASHING when the trap timer expires.

Top module: `sqc_ctrl`

## Requirements
- R1: After reset, `thr_state` is 0 (RUNNING), and `sq_valid` and `rob_squashing` are 0.
- R2: An execute squash is accepted only when `exe_seq` is unsigned less than or equal to the youngest recorded sequence number. That number is set by `alloc_valid`/`alloc_seq`, and by the boundary of the last accepted squash.
- R3: When `exe_include` is 1, both `sq_seq` and `sq_rob_seq` are one lower than they would otherwise be.
- R4: On a mispredict (`exe_mispredict`=1) that is taken and is a conditional delay-slot branch, `sq_rob_seq` equals `sq_seq` and `sq_dslot`=1. On any other mispredict, `sq_rob_seq` equals `sq_seq`+1 and `sq_dslot`=0. Without a mispredict, `sq_rob_seq` equals `sq_seq`.
- R5: An accepted squash raises `sq_valid` for exactly one cycle, on the clock edge after the request. At the same edge `thr_state` becomes 2 and `rob_squashing` is 1. The youngest record takes the value of `sq_seq`.
- R6: While in ROB_SQUASHING and `rob_walk_done` is 0, `rob_squashing` is 1 in the following cycle. A cycle with `rob_walk_done`=1 returns the state to RUNNING and clears `rob_squashing`.
- R7: A `trap_take` pulse moves the state to TRAP_PENDING. The trap squash appears on `sq_valid` exactly TRAP_LAT clock edges after the edge that sampled `trap_take`.
- R8: While in TRAP_PENDING, execute squashes are ignored.
- R9: A full squash (trap or context) sets `sq_full`=1. Its boundary is `rob_head_seq`-1, or 0 when `rob_empty` is 1. It restarts at `saved_pc` with `sq_mispredict`, `sq_taken` and `sq_dslot` at 0, and it clears the youngest record to 0.
- R10: Trap squashes take priority over context squashes. A context request that arrives while a trap is pending is absorbed by the trap squash and never produces a second squash.
- R11: Allocations are not recorded while the state is ROB_SQUASHING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_take | input | 1 | Trap taken this cycle; starts the latency timer |
| ctx_squash_req | input | 1 | External whole-thread squash request |
| exe_squash | input | 1 | Execute-stage squash request |
| exe_seq | input | SEQ_W | Sequence number of the squashing instruction |
| exe_include | input | 1 | Squash includes the squashing instruction |
| exe_mispredict | input | 1 | Squash is a branch mispredict |
| exe_taken | input | 1 | Mispredicted branch was taken |
| exe_cond_dslot | input | 1 | Branch is a conditional delay-slot branch |
| exe_next_pc | input | PC_W | Redirect PC from execute |
| exe_mispred_pc | input | PC_W | PC of the mispredicted branch |
| alloc_valid | input | 1 | Instruction inserted into the reorder buffer |
| alloc_seq | input | SEQ_W | Sequence number of the inserted instruction |
| rob_head_seq | input | SEQ_W | Sequence number at the buffer head |
| rob_empty | input | 1 | Buffer holds no entries for this thread |
| rob_walk_done | input | 1 | Buffer has finished its squash walk |
| saved_pc | input | PC_W | Restart PC for full squashes |
| sq_valid | output | 1 | One-cycle squash command |
| sq_full | output | 1 | Command is a full-thread squash |
| sq_seq | output | SEQ_W | Done boundary sequence number |
| sq_rob_seq | output | SEQ_W | Boundary passed to the reorder buffer |
| sq_dslot | output | 1 | Delay slot is squashed too |
| sq_mispredict | output | 1 | Command stems from a mispredict |
| sq_taken | output | 1 | Mispredicted branch taken |
| sq_next_pc | output | PC_W | Restart PC |
| sq_mispred_pc | output | PC_W | Mispredicted branch PC |
| rob_squashing | output | 1 | Buffer squash walk in progress |
| thr_state | output | 2 | 0 RUNNING, 1 TRAP_PENDING, 2 ROB_SQUASHING |

## Verification
The bench probes the younger-than-youngest filter at exactly equal and one-above sequence numbers. A design with a strict or reversed comparison would accept or drop the wrong one. It also checks that allocations made during a squash walk are ignored; a design that recorded them would later accept a squash it must reject. Each delay-slot and inclusive-boundary combination is checked against its own expected value, so an off-by-one in either adjustment changes `sq_rob_seq` or `sq_seq`. The trap sequence times the squash to the exact cycle while injecting an execute squash and a context request during the wait. A wrong latency, a leaked execute squash, or a second context squash each shows up on `sq_valid`.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    typedef enum logic [1:0] {
        ST_RUNNING    = 2'd0,
        ST_TRAP_PEND  = 2'd1,
        ST_ROB_SQUASH = 2'd2
    } thr_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FULL = 2'd1,
        SRC_EXE  = 2'd2
    } sq_src_e;

endpackage

// File: rtl/sqc_trap_timer.sv
module sqc_trap_timer #(
    parameter int TRAP_LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    localparam int CNT_W = (TRAP_LAT < 2) ? 1 : $clog2(TRAP_LAT);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TRAP_LAT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign busy = busy_q;
    assign fire = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD_V;
        end else if (fire) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sqc_boundary.sv
module sqc_boundary #(
    parameter int SEQ_W = 16
) (
    input  logic [SEQ_W-1:0] exe_seq,
    input  logic             exe_include,
    input  logic             exe_mispredict,
    input  logic             exe_taken,
    input  logic             exe_cond_dslot,
    input  logic [SEQ_W-1:0] youngest,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic             rob_empty,
    output logic             exe_in_window,
    output logic [SEQ_W-1:0] exe_done_seq,
    output logic [SEQ_W-1:0] exe_rob_seq,
    output logic             exe_dslot,
    output logic [SEQ_W-1:0] full_seq
);
    logic [SEQ_W-1:0] dec;
    logic             keep_slot;

    always_comb begin
        dec           = exe_include ? SEQ_W'(1) : '0;
        exe_dslot     = exe_mispredict && exe_taken && exe_cond_dslot;
        keep_slot     = exe_mispredict && !exe_dslot;
        exe_done_seq  = exe_seq - dec;
        exe_rob_seq   = keep_slot ? (exe_seq + SEQ_W'(1) - dec) : (exe_seq - dec);
        exe_in_window = (exe_seq <= youngest);
        full_seq      = rob_empty ? '0 : (rob_head_seq - SEQ_W'(1));
    end

endmodule

// File: rtl/sqc_youngest.sv
module sqc_youngest #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [SEQ_W-1:0] ld_val,
    input  logic             alloc_en,
    input  logic [SEQ_W-1:0] alloc_seq,
    output logic [SEQ_W-1:0] youngest
);
    logic [SEQ_W-1:0] yq;

    assign youngest = yq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yq <= '0;
        end else if (clr) begin
            yq <= '0;
        end else if (ld) begin
            yq <= ld_val;
        end else if (alloc_en) begin
            yq <= alloc_seq;
        end
    end

endmodule

// File: rtl/sqc_ctrl.sv
module sqc_ctrl #(
    parameter int SEQ_W    = 16,
    parameter int PC_W     = 32,
    parameter int TRAP_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_take,
    input  logic             ctx_squash_req,
    input  logic             exe_squash,
    input  logic [SEQ_W-1:0] exe_seq,
    input  logic             exe_include,
    input  logic             exe_mispredict,
    input  logic             exe_taken,
    input  logic             exe_cond_dslot,
    input  logic [PC_W-1:0]  exe_next_pc,
    input  logic [PC_W-1:0]  exe_mispred_pc,
    input  logic             alloc_valid,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic [SEQ_W-1:0] rob_head_seq,
    input  logic             rob_empty,
    input  logic             rob_walk_done,
    input  logic [PC_W-1:0]  saved_pc,
    output logic             sq_valid,
    output logic             sq_full,
    output logic [SEQ_W-1:0] sq_seq,
    output logic [SEQ_W-1:0] sq_rob_seq,
    output logic             sq_dslot,
    output logic             sq_mispredict,
    output logic             sq_taken,
    output logic [PC_W-1:0]  sq_next_pc,
    output logic [PC_W-1:0]  sq_mispred_pc,
    output logic             rob_squashing,
    output logic [1:0]       thr_state
);
    import sqc_pkg::*;

    thr_state_e       state_q, state_d;
    sq_src_e          src;
    logic             trap_busy, trap_fire;
    logic             ctx_pend_q, ctx_any, ctx_go, full_go, exe_go;
    logic             exe_in_window, exe_dslot;
    logic [SEQ_W-1:0] exe_done_seq, exe_rob_seq, full_seq, youngest;
    logic             start_trap;

    sqc_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_trap),
        .busy  (trap_busy),
        .fire  (trap_fire)
    );

    sqc_boundary #(.SEQ_W(SEQ_W)) u_bound (
        .exe_seq        (exe_seq),
        .exe_include    (exe_include),
        .exe_mispredict (exe_mispredict),
        .exe_taken      (exe_taken),
        .exe_cond_dslot (exe_cond_dslot),
        .youngest       (youngest),
        .rob_head_seq   (rob_head_seq),
        .rob_empty      (rob_empty),
        .exe_in_window  (exe_in_window),
        .exe_done_seq   (exe_done_seq),
        .exe_rob_seq    (exe_rob_seq),
        .exe_dslot      (exe_dslot),
        .full_seq       (full_seq)
    );

    sqc_youngest #(.SEQ_W(SEQ_W)) u_young (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (full_go),
        .ld        (exe_go),
        .ld_val    (exe_done_seq),
        .alloc_en  (alloc_valid && (state_q != ST_ROB_SQUASH)),
        .alloc_seq (alloc_seq),
        .youngest  (youngest)
    );

    // Source arbitration: trap first, then context, then execute.
    always_comb begin
        start_trap = trap_take && (state_q != ST_TRAP_PEND);
        ctx_any    = ctx_squash_req || ctx_pend_q;
        ctx_go     = ctx_any && (state_q != ST_TRAP_PEND) && !trap_take;
        full_go    = trap_fire || ctx_go;
        exe_go     = exe_squash && exe_in_window && !full_go &&
                     (state_q != ST_TRAP_PEND) && !trap_take;
        if (full_go)     src = SRC_FULL;
        else if (exe_go) src = SRC_EXE;
        else             src = SRC_NONE;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUNNING: begin
                if (start_trap)            state_d = ST_TRAP_PEND;
                else if (src != SRC_NONE)  state_d = ST_ROB_SQUASH;
            end
            ST_TRAP_PEND: begin
                if (trap_fire)             state_d = ST_ROB_SQUASH;
            end
            ST_ROB_SQUASH: begin
                if (start_trap)            state_d = ST_TRAP_PEND;
                else if (src != SRC_NONE)  state_d = ST_ROB_SQUASH;
                else if (rob_walk_done)    state_d = ST_RUNNING;
            end
            default:                       state_d = ST_RUNNING;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUNNING;
            ctx_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (trap_fire || ctx_go) ctx_pend_q <= 1'b0;
            else if (ctx_squash_req) ctx_pend_q <= 1'b1;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_valid      <= 1'b0;
            sq_full       <= 1'b0;
            sq_seq        <= '0;
            sq_rob_seq    <= '0;
            sq_dslot      <= 1'b0;
            sq_mispredict <= 1'b0;
            sq_taken      <= 1'b0;
            sq_next_pc    <= '0;
            sq_mispred_pc <= '0;
            rob_squashing <= 1'b0;
        end else begin
            sq_valid      <= (src != SRC_NONE);
            rob_squashing <= (src != SRC_NONE) ||
                             ((state_q == ST_ROB_SQUASH) && !rob_walk_done);
            unique case (src)
                SRC_FULL: begin
                    sq_full       <= 1'b1;
                    sq_seq        <= full_seq;
                    sq_rob_seq    <= full_seq;
                    sq_dslot      <= 1'b0;
                    sq_mispredict <= 1'b0;
                    sq_taken      <= 1'b0;
                    sq_next_pc    <= saved_pc;
                    sq_mispred_pc <= '0;
                end
                SRC_EXE: begin
                    sq_full       <= 1'b0;
                    sq_seq        <= exe_done_seq;
                    sq_rob_seq    <= exe_rob_seq;
                    sq_dslot      <= exe_dslot;
                    sq_mispredict <= exe_mispredict;
                    sq_taken      <= exe_taken;
                    sq_next_pc    <= exe_next_pc;
                    sq_mispred_pc <= exe_mispred_pc;
                end
                default: ;
            endcase
        end
    end

    assign thr_state = state_q;

endmodule

// File: rtl/sqc_ctrl_chk.sv
module sqc_ctrl_chk #(
    parameter int SEQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sq_valid,
    input logic             sq_full,
    input logic             sq_dslot,
    input logic             sq_mispredict,
    input logic             sq_taken,
    input logic             rob_squashing,
    input logic             rob_walk_done,
    input logic [1:0]       thr_state,
    input logic             trap_fire,
    input logic [SEQ_W-1:0] youngest,
    input logic [SEQ_W-1:0] sq_seq
);
    // R5
    sq_enters_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |-> (rob_squashing && thr_state == 2'd2));

    // R5
    sq_sets_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !sq_full) |-> (youngest == sq_seq));

    // R6
    walk_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_state == 2'd2 && !rob_walk_done) |=> rob_squashing);

    // R8
    trap_wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_state == 2'd1 && !trap_fire) |=> !sq_valid);

    // R9
    full_no_mispredict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_full) |-> (!sq_mispredict && !sq_taken && !sq_dslot && youngest == '0));

    // R4
    dslot_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && sq_dslot) |-> (sq_mispredict && sq_taken));

endmodule

bind sqc_ctrl sqc_ctrl_chk #(.SEQ_W(SEQ_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sq_valid      (sq_valid),
    .sq_full       (sq_full),
    .sq_dslot      (sq_dslot),
    .sq_mispredict (sq_mispredict),
    .sq_taken      (sq_taken),
    .rob_squashing (rob_squashing),
    .rob_walk_done (rob_walk_done),
    .thr_state     (thr_state),
    .trap_fire     (trap_fire),
    .youngest      (youngest),
    .sq_seq        (sq_seq)
);

// File: tb/sqc_ctrl_tb.sv
module sqc_ctrl_tb;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_take = 0, ctx_squash_req = 0, exe_squash = 0;
    logic [SEQ_W-1:0] exe_seq = '0;
    logic exe_include = 0, exe_mispredict = 0, exe_taken = 0, exe_cond_dslot = 0;
    logic [PC_W-1:0] exe_next_pc = 32'h1000, exe_mispred_pc = 32'h2000;
    logic alloc_valid = 0;
    logic [SEQ_W-1:0] alloc_seq = '0, rob_head_seq = 16'd40;
    logic rob_empty = 0, rob_walk_done = 0;
    logic [PC_W-1:0] saved_pc = 32'h3000;
    logic sq_valid, sq_full, sq_dslot, sq_mispredict, sq_taken, rob_squashing;
    logic [SEQ_W-1:0] sq_seq, sq_rob_seq;
    logic [PC_W-1:0] sq_next_pc, sq_mispred_pc;
    logic [1:0] thr_state;

    int n_chk = 0, n_bad = 0;
    logic done = 0;

    always #2.5 clk = ~clk;

    sqc_ctrl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .TRAP_LAT(3)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [15:0] s);
        alloc_valid = 1; alloc_seq = s; cyc(); alloc_valid = 0;
    endtask

    task automatic do_exe(input logic [15:0] s, input logic inc, mp, tk, cd);
        exe_squash = 1; exe_seq = s; exe_include = inc;
        exe_mispredict = mp; exe_taken = tk; exe_cond_dslot = cd;
        cyc();
        exe_squash = 0; exe_include = 0; exe_mispredict = 0; exe_taken = 0; exe_cond_dslot = 0;
    endtask

    task automatic do_ctx();
        ctx_squash_req = 1; cyc(); ctx_squash_req = 0;
    endtask

    task automatic walk_done();
        rob_walk_done = 1; cyc(); rob_walk_done = 0;
        chk("R6 state back to running", 32'(thr_state), 0);
        chk("R6 rob_squashing cleared", 32'(rob_squashing), 0);
    endtask

    task automatic t_reset();
        chk("R1 state", 32'(thr_state), 0);
        chk("R1 sq_valid", 32'(sq_valid), 0);
        chk("R1 rob_squashing", 32'(rob_squashing), 0);
    endtask

    task automatic t_exe_basic();
        do_alloc(16'd100);
        do_exe(16'd90, 0, 0, 0, 0);
        chk("R5 sq_valid", 32'(sq_valid), 1);
        chk("R5 sq_seq", 32'(sq_seq), 90);
        chk("R4 rob seq no mispredict", 32'(sq_rob_seq), 90);
        chk("R5 state", 32'(thr_state), 2);
        chk("R5 rob_squashing", 32'(rob_squashing), 1);
        chk("R5 next pc", sq_next_pc, 32'h1000);
        chk("R5 not full", 32'(sq_full), 0);
        cyc();
        chk("R5 one-cycle pulse", 32'(sq_valid), 0);
        chk("R6 reassert", 32'(rob_squashing), 1);
        cyc();
        chk("R6 reassert again", 32'(rob_squashing), 1);
        walk_done();
    endtask

    task automatic t_window();
        do_exe(16'd80, 0, 0, 0, 0);
        chk("R2 accept below youngest", 32'(sq_valid), 1);
        do_alloc(16'd200);
        walk_done();
        do_exe(16'd150, 0, 0, 0, 0);
        chk("R11 alloc in walk ignored", 32'(sq_valid), 0);
        do_exe(16'd81, 0, 0, 0, 0);
        chk("R2 reject youngest+1", 32'(sq_valid), 0);
        chk("R2 state stays running", 32'(thr_state), 0);
        do_exe(16'd80, 0, 0, 0, 0);
        chk("R2 accept equal", 32'(sq_valid), 1);
        walk_done();
    endtask

    task automatic t_adjust();
        do_alloc(16'd300);
        do_exe(16'd250, 1, 0, 0, 0);
        chk("R3 include seq", 32'(sq_seq), 249);
        chk("R3 include rob seq", 32'(sq_rob_seq), 249);
        walk_done();
        do_alloc(16'd400);
        do_exe(16'd350, 0, 1, 1, 1);
        chk("R4 dslot seq", 32'(sq_seq), 350);
        chk("R4 dslot rob seq", 32'(sq_rob_seq), 350);
        chk("R4 dslot flag", 32'(sq_dslot), 1);
        chk("R4 mispredict flag", 32'(sq_mispredict), 1);
        chk("R4 mispredict pc", sq_mispred_pc, 32'h2000);
        walk_done();
        do_alloc(16'd400);
        do_exe(16'd350, 0, 1, 1, 0);
        chk("R4 slot kept rob seq", 32'(sq_rob_seq), 351);
        chk("R4 slot kept flag", 32'(sq_dslot), 0);
        walk_done();
        do_alloc(16'd400);
        do_exe(16'd350, 1, 1, 0, 0);
        chk("R3 include with mispredict seq", 32'(sq_seq), 349);
        chk("R4 include with mispredict rob seq", 32'(sq_rob_seq), 350);
        walk_done();
    endtask

    task automatic t_full_ctx();
        do_ctx();
        chk("R9 sq_valid", 32'(sq_valid), 1);
        chk("R9 full flag", 32'(sq_full), 1);
        chk("R9 head-1 boundary", 32'(sq_seq), 39);
        chk("R9 mispredict clear", 32'(sq_mispredict), 0);
        chk("R9 saved pc", sq_next_pc, 32'h3000);
        walk_done();
        do_exe(16'd1, 0, 0, 0, 0);
        chk("R9 youngest cleared reject", 32'(sq_valid), 0);
        do_exe(16'd0, 0, 0, 0, 0);
        chk("R9 youngest cleared accept 0", 32'(sq_valid), 1);
        walk_done();
        rob_empty = 1;
        do_ctx();
        chk("R9 empty boundary", 32'(sq_seq), 0);
        rob_empty = 0;
        walk_done();
    endtask

    task automatic t_trap();
        do_alloc(16'd500);
        trap_take = 1; cyc(); trap_take = 0;
        chk("R7 trap pending state", 32'(thr_state), 1);
        chk("R7 no early squash", 32'(sq_valid), 0);
        do_exe(16'd400, 0, 0, 0, 0);
        chk("R8 exe ignored in trap wait", 32'(sq_valid), 0);
        do_ctx();
        chk("R10 ctx waits for trap", 32'(sq_valid), 0);
        chk("R7 still pending", 32'(thr_state), 1);
        cyc();
        chk("R7 trap squash on time", 32'(sq_valid), 1);
        chk("R7 trap squash full", 32'(sq_full), 1);
        chk("R7 state walking", 32'(thr_state), 2);
        cyc();
        chk("R10 ctx absorbed", 32'(sq_valid), 0);
        walk_done();
        cyc();
        chk("R10 no late ctx squash", 32'(sq_valid), 0);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        t_reset();
        t_exe_basic();
        t_window();
        t_adjust();
        t_full_ctx();
        t_trap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule